// File: doc/BRIEF.md
# SPI Event and Interrupt Logic

This block holds the status and interrupt state of a queued SPI controller. It sits between a 32-bit register bus and a set of status signals from the shift engine and the two word queues. It keeps three registers, each at its own word address: event, mask and command.

The event register mixes two kinds of bits. Some are level bits that simply mirror the queues and the busy line. The others are sticky error and completion bits, which software clears by writing 1. The mask register picks which events may interrupt. A single interrupt line pulses for one clock whenever an enabled event bit goes from 0 to 1. The command register arms a one-shot "last" detector. Once it is armed, the next finished character with an empty transmit queue sets a sticky completion event.

When a master starts a transfer in slave mode while the transmit queue is empty, the block flags an underrun. It also tells the transmit path to answer with a word of all ones.

Top module: `spi_evt_irq`

## Requirements
- R1: While rst_ni is low, every register is zero: event, mask and the last arm. irq_o and tx_all_ones_o are low as well.
- R2: Three event bits are level bits, each following its input one clock later. Bit 31 follows busy_i. Bit 9 is 1 when rxq_count_i is non-zero. Bit 8 is 1 when txq_count_i is below TXQ_DEPTH. Bus writes to these bits have no effect.
- R3: Event bit 12 (overrun) is set when rx_word_i is high while rxq_count_i equals RXQ_DEPTH. It is not set for a word that arrives while the queue has room. Once set, it stays set.
- R4: Event bit 11 (underrun) is set only when slave_mode_i and xfer_start_i are both high while txq_count_i is 0. A start in master mode does not set it, and neither does a start with words queued.
- R5: tx_all_ones_o goes high one clock after an underrun start. It stays high until char_done_i is seen.
- R6: Writing 1 to event bits 14, 12 or 11 at address 0 clears them. Writing 0 leaves them as they are. If a clear and a set of the same bit arrive in the same clock, the bit stays set.
- R7: Writing 1 to bit 22 at command address 2 arms the last detector. The next char_done_i with txq_count_i equal to 0 sets event bit 14 and disarms the detector. A char_done_i while words are still queued does not set the bit. Bit 22 of the command register always reads as 0.
- R8: The mask register sits at address 1. Only bits 31, 14, 12, 11, 10, 9 and 8 can be written; every other bit reads as 0.
- R9: irq_o is high for exactly one clock, in the clock after an event bit whose mask bit is 1 goes from 0 to 1. An event that is masked, stays at 1, or falls raises no interrupt.
- R10: Event bit 10 and all unlisted event bits read as 0. Address 3 reads as 0. bus_rdata_o is 0 whenever bus_rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Word address: 0 event, 1 mask, 2 command |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational) |
| rxq_count_i | input | RX_CW | Words held in the receive queue |
| txq_count_i | input | TX_CW | Words held in the transmit queue |
| slave_mode_i | input | 1 | Controller runs as slave |
| xfer_start_i | input | 1 | A transfer starts this clock |
| rx_word_i | input | 1 | A received word is offered to the receive queue |
| char_done_i | input | 1 | A character finished shifting |
| busy_i | input | 1 | Transfer in progress |
| irq_o | output | 1 | Interrupt pulse |
| tx_all_ones_o | output | 1 | Transmit path must send all ones |

## Verification
The block holds very little state, so a wrong internal value shows up within one or two clocks. A sticky bit stuck high, or one cleared wrongly, shows on the next event read. A wrong previous-value history shows as a missing pulse on irq_o, a pulse that is too wide, or a second pulse, in the clock after the edge. A last detector that stays armed shows as a second completion event on the next qualifying character. The bench drives each condition against its neighbours: a full queue against a nearly full one, a slave-mode start against a master-mode start, and a clear arriving together with a set.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  localparam int TIP_B = 31;
  localparam int LT_B  = 14;
  localparam int OV_B  = 12;
  localparam int UN_B  = 11;
  localparam int MME_B = 10;
  localparam int NE_B  = 9;
  localparam int NF_B  = 8;
  localparam int LST_B = 22;

  localparam logic [31:0] EVT_RD_BITS = 32'h8000_5B00;
  localparam logic [31:0] MASK_WR_BITS = 32'h8000_5F00;

  typedef enum logic [1:0] {
    A_EVT  = 2'd0,
    A_MASK = 2'd1,
    A_CMD  = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/spi_evt_status.sv
module spi_evt_status
  import spi_evt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        busy_i,
  input  logic        rx_nonempty_i,
  input  logic        tx_notfull_i,
  input  logic        ovr_hit_i,
  input  logic        unr_hit_i,
  input  logic        lt_set_i,
  input  logic        char_done_i,
  input  logic [31:0] clr_i,
  output logic [31:0] evt_o,
  output logic        tx_all_ones_o
);
  localparam int NSTK = 3;
  localparam int STK_POS [NSTK] = '{OV_B, UN_B, LT_B};

  logic [NSTK-1:0] stk_set;
  logic [NSTK-1:0] stk_q;
  logic tip_q, ne_q, nf_q, ones_q;

  assign stk_set = {lt_set_i, unr_hit_i, ovr_hit_i};

  // sticky bits: set beats write-one clear
  for (genvar i = 0; i < NSTK; i++) begin : g_stk
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= stk_set[i] | (bit_q & ~clr_i[STK_POS[i]]);
    end
    assign stk_q[i] = bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tip_q  <= 1'b0;
      ne_q   <= 1'b0;
      nf_q   <= 1'b0;
      ones_q <= 1'b0;
    end else begin
      tip_q  <= busy_i;
      ne_q   <= rx_nonempty_i;
      nf_q   <= tx_notfull_i;
      ones_q <= unr_hit_i | (ones_q & ~char_done_i);
    end
  end

  always_comb begin
    evt_o        = '0;
    evt_o[TIP_B] = tip_q;
    evt_o[LT_B]  = stk_q[2];
    evt_o[OV_B]  = stk_q[0];
    evt_o[UN_B]  = stk_q[1];
    evt_o[NE_B]  = ne_q;
    evt_o[NF_B]  = nf_q;
  end

  assign tx_all_ones_o = ones_q;
endmodule

// File: rtl/spi_evt_last.sv
module spi_evt_last (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic char_done_i,
  input  logic tx_empty_i,
  output logic lt_set_o,
  output logic armed_o
);
  logic armed_q;
  logic fire;

  assign fire = armed_q & char_done_i & tx_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= (armed_q & ~fire) | arm_i;
  end

  assign lt_set_o = fire;
  assign armed_o  = armed_q;
endmodule

// File: rtl/spi_evt_irq_gen.sv
module spi_evt_irq_gen #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= evt_i;
  end

  assign irq_o = |(evt_i & ~prev_q & mask_i);
endmodule

// File: rtl/spi_evt_irq.sv
module spi_evt_irq
  import spi_evt_pkg::*;
#(
  parameter int RXQ_DEPTH = 8,
  parameter int TXQ_DEPTH = 8,
  parameter int RX_CW = $clog2(RXQ_DEPTH + 1),
  parameter int TX_CW = $clog2(TXQ_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  input  logic [RX_CW-1:0] rxq_count_i,
  input  logic [TX_CW-1:0] txq_count_i,
  input  logic             slave_mode_i,
  input  logic             xfer_start_i,
  input  logic             rx_word_i,
  input  logic             char_done_i,
  input  logic             busy_i,
  output logic             irq_o,
  output logic             tx_all_ones_o
);
  logic        wr_evt, wr_mask, wr_cmd;
  logic [31:0] clr, evt, mask_q;
  logic        rx_full, tx_empty, ovr_hit, unr_hit, lt_set, armed;

  assign wr_evt  = bus_wr_i && (bus_addr_i == A_EVT);
  assign wr_mask = bus_wr_i && (bus_addr_i == A_MASK);
  assign wr_cmd  = bus_wr_i && (bus_addr_i == A_CMD);
  assign clr     = wr_evt ? bus_wdata_i : '0;

  assign rx_full  = rxq_count_i == RX_CW'(RXQ_DEPTH);
  assign tx_empty = txq_count_i == '0;
  assign ovr_hit  = rx_word_i & rx_full;
  assign unr_hit  = slave_mode_i & xfer_start_i & tx_empty;

  spi_evt_status u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy_i),
    .rx_nonempty_i(rxq_count_i != '0),
    .tx_notfull_i (txq_count_i < TX_CW'(TXQ_DEPTH)),
    .ovr_hit_i    (ovr_hit),
    .unr_hit_i    (unr_hit),
    .lt_set_i     (lt_set),
    .char_done_i  (char_done_i),
    .clr_i        (clr),
    .evt_o        (evt),
    .tx_all_ones_o(tx_all_ones_o)
  );

  spi_evt_last u_last (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (wr_cmd & bus_wdata_i[LST_B]),
    .char_done_i(char_done_i),
    .tx_empty_i (tx_empty),
    .lt_set_o   (lt_set),
    .armed_o    (armed)
  );

  spi_evt_irq_gen #(.W(32)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt),
    .mask_i(mask_q),
    .irq_o (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_mask) mask_q <= bus_wdata_i & MASK_WR_BITS;
  end

  // command register reads as zero
  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      case (bus_addr_i)
        A_EVT:   bus_rdata_o = evt;
        A_MASK:  bus_rdata_o = mask_q;
        default: bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_evt_irq_chk.sv
module spi_evt_irq_chk
  import spi_evt_pkg::*;
#(
  parameter int RXQ_DEPTH = 8,
  parameter int TXQ_DEPTH = 8,
  parameter int RX_CW = $clog2(RXQ_DEPTH + 1),
  parameter int TX_CW = $clog2(TXQ_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_wr_i,
  input logic             bus_rd_i,
  input logic [1:0]       bus_addr_i,
  input logic [31:0]      bus_wdata_i,
  input logic [31:0]      bus_rdata_o,
  input logic [RX_CW-1:0] rxq_count_i,
  input logic [TX_CW-1:0] txq_count_i,
  input logic             slave_mode_i,
  input logic             xfer_start_i,
  input logic             rx_word_i,
  input logic             char_done_i,
  input logic             irq_o,
  input logic             tx_all_ones_o,
  input logic [31:0]      evt_i,
  input logic [31:0]      mask_i,
  input logic             armed_i
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assert_ne_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (evt_i[NE_B] == ($past(rxq_count_i) != '0)));

  assert_ovr_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_word_i && rxq_count_i == RX_CW'(RXQ_DEPTH)) |=> evt_i[OV_B]);

  assert_unr_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $rose(evt_i[UN_B])) |->
      $past(slave_mode_i && xfer_start_i && txq_count_i == '0));

  assert_all_ones_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_mode_i && xfer_start_i && txq_count_i == '0) |=> tx_all_ones_o);

  assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == A_EVT && bus_wdata_i[OV_B] && evt_i[OV_B] &&
     !(rx_word_i && rxq_count_i == RX_CW'(RXQ_DEPTH))) |=> !evt_i[OV_B]);

  assert_last_fire_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && char_done_i && txq_count_i == '0 &&
     !(bus_wr_i && bus_addr_i == A_CMD && bus_wdata_i[LST_B])) |=>
      (evt_i[LT_B] && !armed_i));

  assert_mask_bits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i & ~MASK_WR_BITS) == '0);

  assert_irq_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $rose(evt_i[OV_B]) && mask_i[OV_B]) |-> irq_o);

  assert_rsv_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |-> (bus_rdata_o == '0));
endmodule

bind spi_evt_irq spi_evt_irq_chk #(
  .RXQ_DEPTH(RXQ_DEPTH),
  .TXQ_DEPTH(TXQ_DEPTH)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_wr_i     (bus_wr_i),
  .bus_rd_i     (bus_rd_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .rxq_count_i  (rxq_count_i),
  .txq_count_i  (txq_count_i),
  .slave_mode_i (slave_mode_i),
  .xfer_start_i (xfer_start_i),
  .rx_word_i    (rx_word_i),
  .char_done_i  (char_done_i),
  .irq_o        (irq_o),
  .tx_all_ones_o(tx_all_ones_o),
  .evt_i        (evt),
  .mask_i       (mask_q),
  .armed_i      (armed)
);

// File: tb/spi_evt_irq_bench.sv
`timescale 1ns/1ps
module spi_evt_irq_bench;
  localparam int RXD = 8;
  localparam int TXD = 8;
  localparam int RCW = $clog2(RXD + 1);
  localparam int TCW = $clog2(TXD + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr = 1'b0, rd = 1'b0;
  logic [1:0]     addr = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic [RCW-1:0] rxq = '0;
  logic [TCW-1:0] txq = '0;
  logic           slave = 1'b0, start = 1'b0, rxw = 1'b0, cdone = 1'b0, busy = 1'b0;
  logic           irq, ones;
  int             n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  spi_evt_irq #(.RXQ_DEPTH(RXD), .TXQ_DEPTH(TXD)) u_spi_evt_irq (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rxq_count_i(rxq), .txq_count_i(txq), .slave_mode_i(slave),
    .xfer_start_i(start), .rx_word_i(rxw), .char_done_i(cdone),
    .busy_i(busy), .irq_o(irq), .tx_all_ones_o(ones)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1; #1; d = rdata; rd = 1'b0; addr = '0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd_reg(2'd0, d); check("R1 event in reset", d, 32'h0);
    rd_reg(2'd1, d); check("R1 mask in reset", d, 32'h0);
    check("R1 irq in reset", {31'h0, irq}, 32'h0);
    check("R1 all-ones in reset", {31'h0, ones}, 32'h0);
    @(negedge clk); rst_n = 1'b1; step;
  endtask

  task automatic t_level;
    logic [31:0] d;
    rxq = 3; busy = 1'b1; step;
    rd_reg(2'd0, d); check("R2 levels tip/ne/nf", d, 32'h8000_0300);
    rxq = 0; busy = 1'b0; txq = TCW'(TXD); step;
    rd_reg(2'd0, d); check("R2 levels cleared", d, 32'h0);
    rxq = 2; step;
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_reg(2'd0, d); check("R2 write ignored", d, 32'h0000_0200);
    rxq = 0; txq = 0; step; step;
    rd_reg(2'd0, d); check("R2 not full back", d, 32'h0000_0100);
  endtask

  task automatic t_overrun;
    logic [31:0] d;
    rxq = RCW'(RXD - 1); rxw = 1'b1; step; rxw = 1'b0; step;
    rd_reg(2'd0, d); check("R3 no overrun with room", d & 32'h1000, 32'h0);
    rxq = RCW'(RXD); rxw = 1'b1; step; rxw = 1'b0; step;
    rd_reg(2'd0, d); check("R3 overrun sticky", d & 32'h1000, 32'h1000);
    wr_reg(2'd0, 32'h0);
    rd_reg(2'd0, d); check("R6 write 0 keeps", d & 32'h1000, 32'h1000);
    wr_reg(2'd0, 32'h1000);
    rd_reg(2'd0, d); check("R6 write 1 clears", d & 32'h1000, 32'h0);
    @(negedge clk); rxw = 1'b1; wr = 1'b1; addr = 2'd0; wdata = 32'h1000;
    @(negedge clk); rxw = 1'b0; wr = 1'b0; wdata = '0;
    rd_reg(2'd0, d); check("R6 set wins over clear", d & 32'h1000, 32'h1000);
    wr_reg(2'd0, 32'h1000);
    rxq = 0; step;
  endtask

  task automatic t_underrun;
    logic [31:0] d;
    slave = 1'b0; start = 1'b1; step; start = 1'b0;
    rd_reg(2'd0, d); check("R4 master start no underrun", d & 32'h800, 32'h0);
    check("R5 no all-ones in master", {31'h0, ones}, 32'h0);
    slave = 1'b1; txq = 3; start = 1'b1; step; start = 1'b0;
    rd_reg(2'd0, d); check("R4 queued words no underrun", d & 32'h800, 32'h0);
    txq = 0; start = 1'b1; step; start = 1'b0;
    rd_reg(2'd0, d); check("R4 underrun set", d & 32'h800, 32'h800);
    check("R5 all-ones raised", {31'h0, ones}, 32'h1);
    step; check("R5 all-ones held", {31'h0, ones}, 32'h1);
    cdone = 1'b1; step; cdone = 1'b0;
    check("R5 all-ones dropped", {31'h0, ones}, 32'h0);
    wr_reg(2'd0, 32'h800);
    rd_reg(2'd0, d); check("R6 underrun cleared", d & 32'h800, 32'h0);
    slave = 1'b0;
  endtask

  task automatic t_last;
    logic [31:0] d;
    wr_reg(2'd2, 32'h0040_0000);
    rd_reg(2'd2, d); check("R7 command reads zero", d, 32'h0);
    txq = 2; cdone = 1'b1; step; cdone = 1'b0;
    rd_reg(2'd0, d); check("R7 no event with queued words", d & 32'h4000, 32'h0);
    txq = 0; cdone = 1'b1; step; cdone = 1'b0;
    rd_reg(2'd0, d); check("R7 last event set", d & 32'h4000, 32'h4000);
    wr_reg(2'd0, 32'h4000);
    cdone = 1'b1; step; cdone = 1'b0;
    rd_reg(2'd0, d); check("R7 detector disarmed", d & 32'h4000, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr_reg(2'd1, 32'hFFFF_FFFF);
    rd_reg(2'd1, d); check("R8 writable mask bits", d, 32'h8000_5F00);
    wr_reg(2'd1, 32'h0);
    rd_reg(2'd1, d); check("R8 mask cleared", d, 32'h0);
  endtask

  task automatic t_irq;
    rxq = 1; step;
    check("R9 masked rise no irq", {31'h0, irq}, 32'h0);
    rxq = 0; step;
    wr_reg(2'd1, 32'h0000_1200);
    rxq = 1; step;
    check("R9 irq pulse on not-empty", {31'h0, irq}, 32'h1);
    step; check("R9 pulse one clock", {31'h0, irq}, 32'h0);
    rxq = 0; step;
    check("R9 fall no irq", {31'h0, irq}, 32'h0);
    rxq = RCW'(RXD); rxw = 1'b1; step; rxw = 1'b0;
    check("R9 irq on overrun", {31'h0, irq}, 32'h1);
    rxw = 1'b1; step; rxw = 1'b0;
    check("R9 held event no irq", {31'h0, irq}, 32'h0);
    wr_reg(2'd0, 32'h1000); wr_reg(2'd1, 32'h0);
    rxq = 0; step; step;
  endtask

  task automatic t_rsv;
    logic [31:0] d;
    busy = 1'b1; rxq = 1; slave = 1'b1; start = 1'b1; step; start = 1'b0; slave = 1'b0;
    rd_reg(2'd0, d); check("R10 reserved event bits zero", d & ~32'h8000_5B00, 32'h0);
    rd_reg(2'd3, d); check("R10 address 3 zero", d, 32'h0);
    addr = 2'd0; rd = 1'b0; #1;
    check("R10 no read strobe zero", rdata, 32'h0);
    busy = 1'b0; rxq = 0; cdone = 1'b1; step; cdone = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2;
    t_reset;
    t_level;
    t_overrun;
    t_underrun;
    t_last;
    t_mask;
    t_irq;
    t_rsv;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule